// File: doc/BRIEF.md
# Multi-Lane Double-Rate Link Transmit Framer

This block is the sending half of a packet-based, point-to-point duplex link. Two valid/ready streams feed it 32-bit words: one carries data, the other control. The framer cuts each word into slices as wide as the active lane group and drives two slices per clock cycle. One slice is tied to the rising edge and one to the falling edge. A per-beat flag beside the lanes tells the far end whether that beat is control or data. Control words take precedence over data at every word boundary, so a control word can be slipped in between two words of a data packet that is already moving. The data packet then carries on where it stopped.

The lane group is 2, 4, 8, 16 or 32 lanes wide. The width is taken from a code input while reset is held and stays fixed until the next reset. Because of this, the sending width does not depend on whatever width the opposite direction uses. A small enable vector tells the pad logic how many forwarded clock lanes the chosen width needs. When there is nothing to send, the lanes stay at zero and the flag stays high.

Top module: `lane_tx_framer`

## Requirements
- R1: The width code sets the lane count: 0→2, 1→4, 2→8, 3→16, 4→32, and codes 5 to 7 select 2. The code is captured only while rst_n is low, so a change after reset has no effect on slicing or clock enables.
- R2: A word goes out least-significant slice first, W bits per beat on lanes [W-1:0], over 32/W beats. Lanes at and above W are always zero.
- R3: Each cycle carries two beats, rising beat first and falling beat second. A word continues from one beat to the next with no gap while it lasts.
- R4: The beat flag (ctl_rise / ctl_fall) is 1 on every beat of a control word and 0 on every beat of a data word.
- R5: On a beat with no word to send, the lanes are all zero and the flag is 1. This is also the output state after reset.
- R6: At a word boundary, a valid control word is always taken before a valid data word.
- R7: Once a word has started, no new word is accepted until its last beat has been scheduled. Both ready outputs stay low in the meantime.
- R8: A data word that was held back by a control word is sent right after that control word, with its slices intact.
- R9: The clock enable vector is 0001 for widths 2 to 8, 0011 for width 16 and 1111 for width 32. It is constant between resets.
- R10: At width 32, one cycle can carry two words, at most one from each stream. When both are valid, control takes the rising beat and data takes the falling beat.
- R11: A ready output is high in the cycle in which its word is taken. The first beats of that word appear on the lane outputs right after that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; each cycle holds a rising and a falling beat |
| rst_n | input | 1 | Synchronous active-low reset; the width code is captured while it is low |
| width_code | input | 3 | Lane width selector (see R1) |
| ctl_valid | input | 1 | Control word offered |
| ctl_word | input | 32 | Control word |
| ctl_ready | output | 1 | Control word taken at this clock edge |
| data_valid | input | 1 | Data word offered |
| data_word | input | 32 | Data word |
| data_ready | output | 1 | Data word taken at this clock edge |
| lane_rise | output | 32 | Lane values for the rising-edge beat |
| lane_fall | output | 32 | Lane values for the falling-edge beat |
| ctl_rise | output | 1 | Control/data flag of the rising beat |
| ctl_fall | output | 1 | Control/data flag of the falling beat |
| clk_en | output | 4 | Active forwarded clock lanes |

## Verification
A wrong beat counter shows up on the very next cycle in one of two ways. A ready rises in the middle of a word, or the next word's slices begin before the current word's top slice has gone out. A wrong shift amount or lane mask corrupts the second beat of any word at widths below 32. A captured width that drifts after reset changes clk_en and the slice size at once. A lost or swapped priority choice is visible as the wrong ready in the boundary cycle, and as the wrong flag one cycle after it.

// File: rtl/lane_tx_pkg.sv
package lane_tx_pkg;
    localparam int WORD_W    = 32;
    localparam int LANES     = WORD_W;
    localparam int CNT_W     = $clog2(WORD_W / 2) + 1;
    localparam int SH_W      = $clog2(WORD_W) + 1;
    localparam int CLK_LANES = 4;
    localparam int EDGES     = 2;
    localparam int MAX_CODE  = 4;

    typedef logic [2:0] wcode_t;

    // word being serialised: remaining bits, beats still owed, kind
    typedef struct packed {
        logic [WORD_W-1:0] rest;
        logic [CNT_W-1:0]  left;
        logic              is_ctl;
    } seg_t;

    typedef struct packed {
        seg_t             seg;
        logic [LANES-1:0] rise;
        logic [LANES-1:0] fall;
        logic             ctl_r;
        logic             ctl_f;
    } tx_state_t;
endpackage

// File: rtl/lane_tx_cfg.sv
module lane_tx_cfg
    import lane_tx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  wcode_t               width_code,
    output wcode_t               code_q,
    output logic [SH_W-1:0]      shamt,
    output logic [CNT_W-1:0]     beats_m1,
    output logic [LANES-1:0]     lane_mask,
    output logic [CLK_LANES-1:0] clk_en
);
    localparam int LANES_PER_CLK = LANES / CLK_LANES;

    wcode_t code_d;
    wcode_t eff;

    always_comb begin
        code_d = rst_n ? code_q : width_code;
    end

    always_ff @(posedge clk) begin
        code_q <= code_d;
    end

    always_comb begin
        eff      = (int'(code_q) <= MAX_CODE) ? code_q : wcode_t'(0);
        shamt    = SH_W'(2 << eff);
        beats_m1 = CNT_W'((WORD_W >> (int'(eff) + 1)) - 1);
        for (int i = 0; i < LANES; i++) begin
            lane_mask[i] = (i < int'(shamt));
        end
        for (int k = 0; k < CLK_LANES; k++) begin
            clk_en[k] = (int'(shamt) > k * LANES_PER_CLK);
        end
    end
endmodule

// File: rtl/lane_tx_slice.sv
module lane_tx_slice
    import lane_tx_pkg::*;
(
    input  seg_t              seg_in,
    input  logic              ctl_avail,
    input  logic              data_avail,
    input  logic [WORD_W-1:0] ctl_word,
    input  logic [WORD_W-1:0] data_word,
    input  logic [SH_W-1:0]   shamt,
    input  logic [CNT_W-1:0]  beats_m1,
    input  logic [LANES-1:0]  lane_mask,
    output logic [LANES-1:0]  beat,
    output logic              beat_ctl,
    output seg_t              seg_out,
    output logic              take_ctl,
    output logic              take_data
);
    logic [WORD_W-1:0] src;
    logic              src_ctl;
    logic              fresh;

    always_comb begin
        take_ctl  = 1'b0;
        take_data = 1'b0;
        fresh     = 1'b0;
        src       = seg_in.rest;
        src_ctl   = seg_in.is_ctl;
        if (seg_in.left == '0) begin
            if (ctl_avail) begin
                take_ctl = 1'b1;
                fresh    = 1'b1;
                src      = ctl_word;
                src_ctl  = 1'b1;
            end else if (data_avail) begin
                take_data = 1'b1;
                fresh     = 1'b1;
                src       = data_word;
                src_ctl   = 1'b0;
            end else begin
                src     = '0;
                src_ctl = 1'b1;
            end
        end
        beat           = src & lane_mask;
        beat_ctl       = src_ctl;
        seg_out.rest   = src >> shamt;
        seg_out.is_ctl = src_ctl;
        if (fresh) begin
            seg_out.left = beats_m1;
        end else if (seg_in.left != '0) begin
            seg_out.left = seg_in.left - 1'b1;
        end else begin
            seg_out.left = '0;
        end
    end
endmodule

// File: rtl/lane_tx_framer.sv
module lane_tx_framer
    import lane_tx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           width_code,
    input  logic                 ctl_valid,
    input  logic [31:0]          ctl_word,
    output logic                 ctl_ready,
    input  logic                 data_valid,
    input  logic [31:0]          data_word,
    output logic                 data_ready,
    output logic [31:0]          lane_rise,
    output logic [31:0]          lane_fall,
    output logic                 ctl_rise,
    output logic                 ctl_fall,
    output logic [3:0]           clk_en
);
    localparam tx_state_t ST_IDLE = '{
        seg:   '{rest: '0, left: '0, is_ctl: 1'b1},
        rise:  '0,
        fall:  '0,
        ctl_r: 1'b1,
        ctl_f: 1'b1
    };

    wcode_t           cfg_code;
    logic [SH_W-1:0]  shamt;
    logic [CNT_W-1:0] beats_m1;
    logic [LANES-1:0] lane_mask;

    tx_state_t st_d, st_q;

    seg_t             seg_chain [EDGES+1];
    logic [LANES-1:0] beat_v    [EDGES];
    logic             beat_c    [EDGES];
    logic             tc        [EDGES];
    logic             td        [EDGES];
    logic             ca        [EDGES];
    logic             da        [EDGES];

    lane_tx_cfg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .width_code (width_code),
        .code_q     (cfg_code),
        .shamt      (shamt),
        .beats_m1   (beats_m1),
        .lane_mask  (lane_mask),
        .clk_en     (clk_en)
    );

    assign seg_chain[0] = st_q.seg;

    // one slicer per clock edge; each edge sees only the streams the
    // earlier edge left untouched
    for (genvar e = 0; e < EDGES; e++) begin : g_edge
        if (e == 0) begin : g_first
            assign ca[e] = ctl_valid & rst_n;
            assign da[e] = data_valid & rst_n;
        end else begin : g_next
            assign ca[e] = ca[e-1] & ~tc[e-1];
            assign da[e] = da[e-1] & ~td[e-1];
        end
        lane_tx_slice u_slice (
            .seg_in     (seg_chain[e]),
            .ctl_avail  (ca[e]),
            .data_avail (da[e]),
            .ctl_word   (ctl_word),
            .data_word  (data_word),
            .shamt      (shamt),
            .beats_m1   (beats_m1),
            .lane_mask  (lane_mask),
            .beat       (beat_v[e]),
            .beat_ctl   (beat_c[e]),
            .seg_out    (seg_chain[e+1]),
            .take_ctl   (tc[e]),
            .take_data  (td[e])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.seg   = seg_chain[EDGES];
        st_d.rise  = beat_v[0];
        st_d.fall  = beat_v[EDGES-1];
        st_d.ctl_r = beat_c[0];
        st_d.ctl_f = beat_c[EDGES-1];
        ctl_ready  = 1'b0;
        data_ready = 1'b0;
        for (int e = 0; e < EDGES; e++) begin
            ctl_ready  = ctl_ready | tc[e];
            data_ready = data_ready | td[e];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign lane_rise = st_q.rise;
    assign lane_fall = st_q.fall;
    assign ctl_rise  = st_q.ctl_r;
    assign ctl_fall  = st_q.ctl_f;
endmodule

// File: rtl/lane_tx_framer_chk.sv
module lane_tx_framer_chk
    import lane_tx_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ctl_valid,
    input logic                 ctl_ready,
    input logic                 data_valid,
    input logic                 data_ready,
    input logic                 ctl_rise,
    input logic                 ctl_fall,
    input logic [LANES-1:0]     lane_rise,
    input logic [LANES-1:0]     lane_fall,
    input logic [CLK_LANES-1:0] clk_en,
    input logic [2:0]           code_q
);
    logic [2:0]       eff;
    logic             w32, w16, wle8;
    logic [LANES-1:0] mask;

    always_comb begin
        eff  = (int'(code_q) <= MAX_CODE) ? code_q : 3'd0;
        w32  = (eff == 3'd4);
        w16  = (eff == 3'd3);
        wle8 = (eff <= 3'd2);
        for (int i = 0; i < LANES; i++) begin
            mask[i] = (i < (2 << eff));
        end
    end

    p_lanes_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((lane_rise | lane_fall) & ~mask) == '0);

    p_ctl_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!w32 && ctl_valid) |-> !data_ready);

    p_word_contiguous_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wle8 && ((ctl_valid && ctl_ready) || (data_valid && data_ready)))
        |=> (!ctl_ready && !data_ready));

    p_clk_en_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(clk_en));

    p_clk_en_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(clk_en) == (w32 ? 4 : (w16 ? 2 : 1)));

    p_w32_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (w32 && ctl_valid && data_valid) |-> (ctl_ready && data_ready));

    p_w32_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (w32 && ctl_valid && ctl_ready && data_valid && data_ready)
        |=> (ctl_rise && !ctl_fall));
endmodule

bind lane_tx_framer lane_tx_framer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_valid  (ctl_valid),
    .ctl_ready  (ctl_ready),
    .data_valid (data_valid),
    .data_ready (data_ready),
    .ctl_rise   (ctl_rise),
    .ctl_fall   (ctl_fall),
    .lane_rise  (lane_rise),
    .lane_fall  (lane_fall),
    .clk_en     (clk_en),
    .code_q     (cfg_code)
);

// File: tb/lane_tx_framer_test.sv
module lane_tx_framer_test;
    localparam int CLK_P    = 10;
    localparam int WATCHDOG = 200000;
    localparam int NVEC     = 7;
    // {width code, is control, word}
    localparam logic [35:0] VEC [NVEC] = '{
        {3'd0, 1'b0, 32'h9E37_79B9},
        {3'd1, 1'b1, 32'h1234_5678},
        {3'd2, 1'b0, 32'hDEAD_BEEF},
        {3'd3, 1'b1, 32'hCAFE_F00D},
        {3'd4, 1'b0, 32'h0F1E_2D3C},
        {3'd5, 1'b1, 32'h8001_7FFE},
        {3'd4, 1'b1, 32'h7654_3210}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  width_code = 3'd0;
    logic        ctl_valid = 1'b0;
    logic [31:0] ctl_word = '0;
    logic        ctl_ready;
    logic        data_valid = 1'b0;
    logic [31:0] data_word = '0;
    logic        data_ready;
    logic [31:0] lane_rise, lane_fall;
    logic        ctl_rise, ctl_fall;
    logic [3:0]  clk_en;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_P / 2) clk = ~clk;

    lane_tx_framer uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .width_code (width_code),
        .ctl_valid  (ctl_valid),
        .ctl_word   (ctl_word),
        .ctl_ready  (ctl_ready),
        .data_valid (data_valid),
        .data_word  (data_word),
        .data_ready (data_ready),
        .lane_rise  (lane_rise),
        .lane_fall  (lane_fall),
        .ctl_rise   (ctl_rise),
        .ctl_fall   (ctl_fall),
        .clk_en     (clk_en)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int width_of(input logic [2:0] c);
        return (c <= 3'd4) ? (2 << c) : 2;
    endfunction

    function automatic logic [3:0] clk_of(input int w);
        return (w == 32) ? 4'b1111 : ((w == 16) ? 4'b0011 : 4'b0001);
    endfunction

    function automatic logic [31:0] slice(input logic [31:0] w, input int k, input int wd);
        logic [63:0] m;
        m = (64'd1 << wd) - 64'd1;
        return 32'((64'(w) >> (k * wd)) & m);
    endfunction

    task automatic do_reset(input logic [2:0] code);
        @(negedge clk);
        rst_n = 1'b0;
        width_code = code;
        ctl_valid = 1'b0;
        data_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic chk_idle(input string req);
        chk({req, " idle rise lanes"}, 64'(lane_rise), 64'd0);
        chk({req, " idle fall lanes"}, 64'(lane_fall), 64'd0);
        chk({req, " idle flags"}, {62'd0, ctl_rise, ctl_fall}, 64'd3);
    endtask

    task automatic chk_beats(input string req, input logic [31:0] r, input logic cr,
                             input logic [31:0] f, input logic cf);
        chk({req, " rise lanes"}, 64'(lane_rise), 64'(r));
        chk({req, " fall lanes"}, 64'(lane_fall), 64'(f));
        chk({req, " flags"}, {62'd0, ctl_rise, ctl_fall}, {62'd0, cr, cf});
    endtask

    initial begin
        #(CLK_P * WATCHDOG);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        // vector walk: one word per width, beats checked slice by slice
        for (int v = 0; v < NVEC; v++) begin
            logic [2:0]  code;
            logic        isc;
            logic [31:0] w;
            int          wd;
            int          n;
            code = VEC[v][35:33];
            isc  = VEC[v][32];
            w    = VEC[v][31:0];
            wd   = width_of(code);
            n    = 32 / wd;
            do_reset(code);
            chk_idle("R5 reset");
            chk("R9 clock enables", 64'(clk_en), 64'(clk_of(wd)));
            if (isc) begin
                ctl_valid = 1'b1; ctl_word = w;
            end else begin
                data_valid = 1'b1; data_word = w;
            end
            #1;
            chk("R11 ready on offer", {62'd0, ctl_ready, data_ready}, {62'd0, isc, !isc});
            @(posedge clk);
            @(negedge clk);
            ctl_valid = 1'b0;
            data_valid = 1'b0;
            for (int k = 0; k < n; k += 2) begin
                if (k + 1 < n)
                    chk_beats("R2 R3 R4 slices", slice(w, k, wd), isc, slice(w, k + 1, wd), isc);
                else
                    chk_beats("R2 R5 last slice", slice(w, k, wd), isc, 32'd0, 1'b1);
                @(negedge clk);
            end
            chk_idle("R5 after word");
        end

        // R6 R7 R8: control cuts in between two data words at width 8
        do_reset(3'd2);
        data_valid = 1'b1; data_word = 32'hA1B2_C3D4;
        @(posedge clk);
        @(negedge clk);
        data_word = 32'h5566_7788;
        ctl_valid = 1'b1; ctl_word = 32'hF0E1_D2C3;
        #1;
        chk("R7 no take inside word", {62'd0, ctl_ready, data_ready}, 64'd0);
        chk_beats("R4 first data beats", 32'hD4, 1'b0, 32'hC3, 1'b0);
        @(negedge clk);
        chk_beats("R3 data word tail", 32'hB2, 1'b0, 32'hA1, 1'b0);
        chk("R6 control wins boundary", {62'd0, ctl_ready, data_ready}, 64'd2);
        @(negedge clk);
        ctl_valid = 1'b0;
        chk_beats("R4 control beats", 32'hC3, 1'b1, 32'hD2, 1'b1);
        #1;
        chk("R7 held during control", {62'd0, ctl_ready, data_ready}, 64'd0);
        @(negedge clk);
        chk_beats("R4 control tail", 32'hE1, 1'b1, 32'hF0, 1'b1);
        chk("R8 data resumes", {62'd0, ctl_ready, data_ready}, 64'd1);
        @(negedge clk);
        data_valid = 1'b0;
        chk_beats("R8 resumed data head", 32'h88, 1'b0, 32'h77, 1'b0);
        @(negedge clk);
        chk_beats("R8 resumed data tail", 32'h66, 1'b0, 32'h55, 1'b0);
        @(negedge clk);
        chk_idle("R5 after packet");

        // R10: both streams at width 32 share one cycle
        do_reset(3'd4);
        ctl_valid = 1'b1; ctl_word = 32'h1357_9BDF;
        data_valid = 1'b1; data_word = 32'h2468_ACE0;
        #1;
        chk("R10 both ready", {62'd0, ctl_ready, data_ready}, 64'd3);
        @(posedge clk);
        @(negedge clk);
        ctl_valid = 1'b0;
        data_valid = 1'b0;
        chk_beats("R10 control rise data fall", 32'h1357_9BDF, 1'b1, 32'h2468_ACE0, 1'b0);

        // R1: width code changed after reset is ignored
        do_reset(3'd0);
        width_code = 3'd4;
        @(negedge clk);
        chk("R1 clock enables kept", 64'(clk_en), 64'h1);
        data_valid = 1'b1; data_word = 32'hFFFF_FFFE;
        @(posedge clk);
        @(negedge clk);
        data_valid = 1'b0;
        chk_beats("R1 width stays 2", 32'h2, 1'b0, 32'h3, 1'b0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule